// File: doc/BRIEF.md
# Fine-Resolution DAC Level Calibrator

This block is a digital controller on the tester side of a multi-level test channel. A digital-to-analog converter (DAC) with a few more bits than the on-chip analog-to-digital converter (ADC) drives the channel. The calibrator finds, for every ADC output code, one fine DAC code that the ADC reliably reads back as that code. This lets the extra DAC resolution absorb the ADC's unequal code widths, so each data symbol is not placed on a fixed ideal step.

When started, the controller steps the fine DAC code upward from zero. After each step it waits a fixed number of settle cycles and then requests an ADC reading. For every ADC code it records the lowest and the highest fine code that produced it. After the last fine code it commits a complete new level table. Inner codes get the midpoint of their measured span. The two end codes, whose input ranges are open on one side, get a level a fixed margin inside the observed edge toward the neighbouring code. A code that never appeared is marked invalid and raises an error flag. Calibration may be repeated at any time to follow drift. The table read port stays usable throughout and keeps serving the previous table until the new one is committed.

Top module: `dac_level_cal`

## Requirements
- R1: After reset, busy, done, cal_err and sample_req are low, and every table entry reads back with rd_valid low.
- R2: A start pulse while idle makes busy high from the next cycle. dac_code is 0 in the first busy cycle and then rises by exactly one per step up to the all-ones fine code.
- R3: Each fine code is held for at least SETTLE_CYCLES cycles before sample_req rises. A reading is taken in the cycle where sample_req and adc_valid are both high. With an ADC that answers one cycle after the request, busy falls at the negative edge counted as 2^FINE_W*(SETTLE_CYCLES+2)+2 from the start edge.
- R4: For an ADC code n other than 0 and the top code, the committed level is (lo+hi)>>1. Here lo and hi are the lowest and highest fine codes whose readback was n.
- R5: Code 0 gets hi-EDGE_MARGIN, but never less than its lo. The top code gets lo+EDGE_MARGIN, but never more than its hi.
- R6: A code that decoded from only one fine code gets exactly that fine code as its level.
- R7: A code never read back during a run is committed with rd_valid low, and cal_err goes high at completion. All observed codes are still committed as valid.
- R8: On the edge where busy falls, done rises and the table and cal_err take their new values. done and cal_err hold until the next accepted start, which clears both.
- R9: rd_level and rd_valid follow rd_addr combinationally from the committed table. The table does not change while a run is in progress.
- R10: A start pulse while busy is ignored. The run neither restarts nor changes length.
- R11: A new run replaces every table entry and cal_err with the results of that run alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calibration run (accepted only when idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | A run has completed since the last accepted start |
| cal_err | output | 1 | Last completed run missed at least one ADC code |
| dac_code | output | ADC_BITS+EXTRA_BITS | Fine code driven to the DAC |
| sample_req | output | 1 | Fine code has settled; ADC reading requested |
| adc_valid | input | 1 | adc_code holds a reading for the current fine code |
| adc_code | input | ADC_BITS | ADC readback code |
| rd_addr | input | ADC_BITS | Table read address (data code) |
| rd_level | output | ADC_BITS+EXTRA_BITS | Fine drive level for rd_addr |
| rd_valid | output | 1 | Entry at rd_addr was observed in the last run |

## Verification
On every cycle, the assertions check several sequencing rules. The fine code only ever climbs by one step or restarts at zero. No reading is requested before the code has settled or outside a run. done is set exactly when busy falls and never while busy. A table entry seen at a fixed address changes only on the completion edge. The level values themselves can only be shown by the bench. It runs a linear ADC, a nonlinear one with a one-level code, and one with a missing code, then compares every entry with midpoints and end-code margins computed from the modelled thresholds. The bench alone also shows that a rerun clears the error and restores entries, and that a start during a run leaves the run length unchanged.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_SAMPLE = 2'd2,
    ST_COMMIT = 2'd3
  } cal_state_e;
endpackage

// File: rtl/cal_sweep_ctrl.sv
`timescale 1ns/1ps
// Sweep sequencer: steps the fine code, waits for settling, requests readings.
module cal_sweep_ctrl import cal_pkg::*; #(
  parameter int FINE_W        = 5,
  parameter int SETTLE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adc_valid,
  output logic [FINE_W-1:0] dac_code,
  output logic              sample_req,
  output logic              busy,
  output logic              clr_en,
  output logic              rec_en,
  output logic              commit_en
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [FINE_W-1:0] CODE_TOP = '1;

  cal_state_e        st_q, st_d;
  logic [FINE_W-1:0] code_q, code_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    st_d      = st_q;
    code_d    = code_q;
    cnt_d     = cnt_q;
    clr_en    = 1'b0;
    rec_en    = 1'b0;
    commit_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_SETTLE;
          code_d = '0;
          cnt_d  = '0;
          clr_en = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (cnt_q == CNT_LAST) st_d = ST_SAMPLE;
        else                   cnt_d = cnt_q + 1'b1;
      end
      ST_SAMPLE: begin
        if (adc_valid) begin
          rec_en = 1'b1;
          if (code_q == CODE_TOP) begin
            st_d = ST_COMMIT;
          end else begin
            code_d = code_q + 1'b1;
            cnt_d  = '0;
            st_d   = ST_SETTLE;
          end
        end
      end
      ST_COMMIT: begin
        commit_en = 1'b1;
        st_d      = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      code_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      code_q <= code_d;
      cnt_q  <= cnt_d;
    end
  end

  assign dac_code   = code_q;
  assign sample_req = (st_q == ST_SAMPLE);
  assign busy       = (st_q != ST_IDLE);
endmodule

// File: rtl/cal_range_track.sv
`timescale 1ns/1ps
// Per-code span tracker: lowest and highest fine code seen for each ADC code.
module cal_range_track #(
  parameter int ADC_W  = 4,
  parameter int FINE_W = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr_en,
  input  logic                           rec_en,
  input  logic [ADC_W-1:0]               rec_code,
  input  logic [FINE_W-1:0]              rec_fine,
  output logic [(1<<ADC_W)-1:0]          seen_o,
  output logic [(1<<ADC_W)-1:0][FINE_W-1:0] lo_o,
  output logic [(1<<ADC_W)-1:0][FINE_W-1:0] hi_o
);
  localparam int CODES = 1 << ADC_W;

  for (genvar g = 0; g < CODES; g++) begin : g_code
    logic              seen_q, seen_d;
    logic [FINE_W-1:0] lo_q, lo_d, hi_q, hi_d;
    logic              hit;

    assign hit = rec_en && (rec_code == ADC_W'(g));

    always_comb begin
      seen_d = seen_q;
      lo_d   = lo_q;
      hi_d   = hi_q;
      if (clr_en) begin
        seen_d = 1'b0;
      end else if (hit) begin
        if (!seen_q) begin
          seen_d = 1'b1;
          lo_d   = rec_fine;
          hi_d   = rec_fine;
        end else begin
          if (rec_fine < lo_q) lo_d = rec_fine;
          if (rec_fine > hi_q) hi_d = rec_fine;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seen_q <= 1'b0;
        lo_q   <= '0;
        hi_q   <= '0;
      end else begin
        seen_q <= seen_d;
        lo_q   <= lo_d;
        hi_q   <= hi_d;
      end
    end

    assign seen_o[g] = seen_q;
    assign lo_o[g]   = lo_q;
    assign hi_o[g]   = hi_q;
  end
endmodule

// File: rtl/cal_level_pick.sv
`timescale 1ns/1ps
// Chooses the drive level for each code from its measured span.
module cal_level_pick #(
  parameter int ADC_W       = 4,
  parameter int FINE_W      = 5,
  parameter int EDGE_MARGIN = 1
) (
  input  logic [(1<<ADC_W)-1:0][FINE_W-1:0] lo_i,
  input  logic [(1<<ADC_W)-1:0][FINE_W-1:0] hi_i,
  output logic [(1<<ADC_W)-1:0][FINE_W-1:0] level_o
);
  localparam int CODES = 1 << ADC_W;
  localparam logic [FINE_W:0]   MARG_X = (FINE_W+1)'(EDGE_MARGIN);
  localparam logic [FINE_W-1:0] MARG_N = FINE_W'(EDGE_MARGIN);

  for (genvar g = 0; g < CODES; g++) begin : g_pick
    logic [FINE_W:0]   lo_x, hi_x;
    logic [FINE_W-1:0] lvl;

    assign lo_x = {1'b0, lo_i[g]};
    assign hi_x = {1'b0, hi_i[g]};

    if (g == 0) begin : g_bottom
      // open below: back off from the boundary with code 1
      always_comb begin
        if (hi_x < lo_x + MARG_X) lvl = lo_i[g];
        else                      lvl = hi_i[g] - MARG_N;
      end
    end else if (g == CODES - 1) begin : g_top
      // open above: step in from the boundary with the code below
      always_comb begin
        if (lo_x + MARG_X > hi_x) lvl = hi_i[g];
        else                      lvl = lo_i[g] + MARG_N;
      end
    end else begin : g_mid
      always_comb lvl = FINE_W'((lo_x + hi_x) >> 1);
    end

    assign level_o[g] = lvl;
  end
endmodule

// File: rtl/dac_level_cal.sv
`timescale 1ns/1ps
// Top: sweep, span tracking, level choice and the committed level table.
module dac_level_cal #(
  parameter int ADC_BITS      = 4,
  parameter int EXTRA_BITS    = 1,
  parameter int SETTLE_CYCLES = 3,
  parameter int EDGE_MARGIN   = 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  output logic                           busy,
  output logic                           done,
  output logic                           cal_err,
  output logic [ADC_BITS+EXTRA_BITS-1:0] dac_code,
  output logic                           sample_req,
  input  logic                           adc_valid,
  input  logic [ADC_BITS-1:0]            adc_code,
  input  logic [ADC_BITS-1:0]            rd_addr,
  output logic [ADC_BITS+EXTRA_BITS-1:0] rd_level,
  output logic                           rd_valid
);
  localparam int FINE_W = ADC_BITS + EXTRA_BITS;
  localparam int CODES  = 1 << ADC_BITS;

  logic clr_en, rec_en, commit_en;
  logic [CODES-1:0]             seen;
  logic [CODES-1:0][FINE_W-1:0] span_lo, span_hi, pick;

  cal_sweep_ctrl #(
    .FINE_W        (FINE_W),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_sweep (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .adc_valid  (adc_valid),
    .dac_code   (dac_code),
    .sample_req (sample_req),
    .busy       (busy),
    .clr_en     (clr_en),
    .rec_en     (rec_en),
    .commit_en  (commit_en)
  );

  cal_range_track #(
    .ADC_W  (ADC_BITS),
    .FINE_W (FINE_W)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_en   (clr_en),
    .rec_en   (rec_en),
    .rec_code (adc_code),
    .rec_fine (dac_code),
    .seen_o   (seen),
    .lo_o     (span_lo),
    .hi_o     (span_hi)
  );

  cal_level_pick #(
    .ADC_W       (ADC_BITS),
    .FINE_W      (FINE_W),
    .EDGE_MARGIN (EDGE_MARGIN)
  ) u_pick (
    .lo_i    (span_lo),
    .hi_i    (span_hi),
    .level_o (pick)
  );

  logic [CODES-1:0][FINE_W-1:0] level_q, level_d;
  logic [CODES-1:0]             valid_q, valid_d;
  logic                         done_q, done_d, err_q, err_d;

  always_comb begin
    level_d = level_q;
    valid_d = valid_q;
    done_d  = done_q;
    err_d   = err_q;
    if (clr_en) begin
      done_d = 1'b0;
      err_d  = 1'b0;
    end
    if (commit_en) begin
      level_d = pick;
      valid_d = seen;
      done_d  = 1'b1;
      err_d   = ~&seen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      valid_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      level_q <= level_d;
      valid_q <= valid_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign done     = done_q;
  assign cal_err  = err_q;
  assign rd_level = level_q[rd_addr];
  assign rd_valid = valid_q[rd_addr];
endmodule

// File: rtl/dac_level_cal_chk.sv
`timescale 1ns/1ps
module dac_level_cal_chk #(
  parameter int ADC_W         = 4,
  parameter int FINE_W        = 5,
  parameter int SETTLE_CYCLES = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [FINE_W-1:0] dac_code,
  input logic              sample_req,
  input logic [ADC_W-1:0]  rd_addr,
  input logic [FINE_W-1:0] rd_level,
  input logic              rd_valid
);
  localparam int AGE_W = $clog2(SETTLE_CYCLES + 1) + 1;
  localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(SETTLE_CYCLES);

  logic [FINE_W-1:0] prev_code_q;
  logic              prev_busy_q;
  logic [AGE_W-1:0]  age_q, age_now;
  logic              fresh;

  assign fresh   = (dac_code != prev_code_q) || (busy && !prev_busy_q);
  assign age_now = fresh ? '0 : age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_code_q <= '0;
      prev_busy_q <= 1'b0;
      age_q       <= '0;
    end else begin
      prev_code_q <= dac_code;
      prev_busy_q <= busy;
      age_q       <= (age_now >= AGE_SAT) ? AGE_SAT : age_now + 1'b1;
    end
  end

  // R2
  fine_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && dac_code != $past(dac_code)) |-> (dac_code == $past(dac_code) + 1'b1));

  // R2
  sweep_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (dac_code == '0));

  // R3
  settle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_req |-> (age_now >= AGE_SAT));

  // R3
  req_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_req |-> busy);

  // R8
  done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  no_done_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  // R9
  table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_addr) && !$fell(busy)) |-> ($stable(rd_level) && $stable(rd_valid)));
endmodule

bind dac_level_cal dac_level_cal_chk #(
  .ADC_W         (ADC_BITS),
  .FINE_W        (FINE_W),
  .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .dac_code   (dac_code),
  .sample_req (sample_req),
  .rd_addr    (rd_addr),
  .rd_level   (rd_level),
  .rd_valid   (rd_valid)
);

// File: tb/dac_level_cal_test.sv
`timescale 1ns/1ps
module dac_level_cal_test;
  localparam int ADC_BITS   = 4;
  localparam int EXTRA_BITS = 1;
  localparam int SETTLE     = 3;
  localparam int MARGIN     = 1;
  localparam int FINE_W     = ADC_BITS + EXTRA_BITS;
  localparam int CODES      = 1 << ADC_BITS;
  localparam int FINE_N     = 1 << FINE_W;
  localparam int RUN_CYC    = FINE_N * (SETTLE + 2) + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, cal_err, sample_req, rd_valid;
  logic [FINE_W-1:0] dac_code, rd_level;
  logic adc_valid;
  logic [ADC_BITS-1:0] adc_code;
  logic [ADC_BITS-1:0] rd_addr = '0;

  int n_chk = 0;
  int n_bad = 0;
  int base_cyc = 0;
  bit finished = 1'b0;
  int thr [CODES];

  always #2.5 clk = ~clk;

  dac_level_cal #(
    .ADC_BITS(ADC_BITS), .EXTRA_BITS(EXTRA_BITS),
    .SETTLE_CYCLES(SETTLE), .EDGE_MARGIN(MARGIN)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .cal_err(cal_err), .dac_code(dac_code), .sample_req(sample_req),
    .adc_valid(adc_valid), .adc_code(adc_code), .rd_addr(rd_addr),
    .rd_level(rd_level), .rd_valid(rd_valid)
  );

  // ADC model: thr[k] is the lowest fine code read back as k (k >= 1)
  always_comb begin
    adc_code = '0;
    for (int k = 1; k < CODES; k++)
      if (int'(dac_code) >= thr[k]) adc_code = ADC_BITS'(k);
  end

  always @(posedge clk or negedge rst_n)
    if (!rst_n) adc_valid <= 1'b0;
    else        adc_valid <= sample_req;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void expected(int k, output int lvl, output int vld);
    int lo, hi;
    lo = (k == 0) ? 0 : thr[k];
    hi = (k == CODES - 1) ? FINE_N - 1 : thr[k+1] - 1;
    vld = (hi >= lo) ? 1 : 0;
    if (k == 0)              lvl = (hi - MARGIN < lo) ? lo : hi - MARGIN;
    else if (k == CODES - 1) lvl = (lo + MARGIN > hi) ? hi : lo + MARGIN;
    else                     lvl = (lo + hi) >> 1;
  endfunction

  task automatic set_linear();
    for (int k = 0; k < CODES; k++) thr[k] = 2 * k;
  endtask

  task automatic read_entry(int k);
    @(negedge clk);
    rd_addr = ADC_BITS'(k);
    #1;
  endtask

  task automatic check_table();
    int lvl, vld;
    for (int k = 0; k < CODES; k++) begin
      expected(k, lvl, vld);
      read_entry(k);
      chk("R7", $sformatf("valid[%0d]", k), int'(rd_valid), vld);
      if (vld == 1) begin
        if (k == 0 || k == CODES - 1)
          chk("R5", $sformatf("end level[%0d]", k), int'(rd_level), lvl);
        else
          chk("R4", $sformatf("mid level[%0d]", k), int'(rd_level), lvl);
      end
    end
  endtask

  task automatic begin_run();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busy after start", int'(busy), 1);
    chk("R2", "first fine code", int'(dac_code), 0);
  endtask

  // counts negedges from the start edge until busy falls; optional extra start
  task automatic finish_run(int already, int poke_at, output int cyc);
    cyc = already;
    while (busy && cyc < 4 * RUN_CYC) begin
      @(negedge clk);
      cyc++;
      start = (cyc == poke_at);
    end
    start = 1'b0;
    chk("R8", "done at finish", int'(done), 1);
    chk("R8", "busy at finish", int'(busy), 0);
  endtask

  task automatic t_reset();
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "cal_err", int'(cal_err), 0);
    chk("R1", "sample_req", int'(sample_req), 0);
    for (int k = 0; k < CODES; k += 5) begin
      read_entry(k);
      chk("R1", $sformatf("valid[%0d]", k), int'(rd_valid), 0);
    end
  endtask

  task automatic t_linear();
    int cyc;
    set_linear();
    begin_run();
    finish_run(1, -1, cyc);
    base_cyc = cyc;
    chk("R3", "run length", cyc, RUN_CYC);
    chk("R7", "cal_err clean", int'(cal_err), 0);
    check_table();
  endtask

  task automatic t_nonlinear();
    int cyc;
    int t [CODES] = '{0, 3, 4, 9, 10, 12, 15, 16, 18, 20, 23, 24, 26, 27, 29, 30};
    for (int k = 0; k < CODES; k++) thr[k] = t[k];
    begin_run();
    finish_run(1, -1, cyc);
    chk("R7", "cal_err clean", int'(cal_err), 0);
    check_table();
    read_entry(1);
    chk("R6", "single-level code", int'(rd_level), 3);
    read_entry(0);
    chk("R5", "bottom margin", int'(rd_level), 1);
  endtask

  task automatic t_missing();
    int cyc;
    set_linear();
    thr[6] = thr[5];   // code 5 never decodes
    begin_run();
    finish_run(1, -1, cyc);
    chk("R7", "cal_err set", int'(cal_err), 1);
    read_entry(5);
    chk("R7", "missing entry invalid", int'(rd_valid), 0);
    check_table();
  endtask

  task automatic t_rerun();
    int cyc;
    set_linear();
    read_entry(5);
    begin_run();
    chk("R8", "err cleared by start", int'(cal_err), 0);
    chk("R8", "done cleared by start", int'(done), 0);
    cyc = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cyc++;
    end
    #1;
    chk("R9", "old entry kept mid-run", int'(rd_valid), 0);
    finish_run(cyc, -1, cyc);
    read_entry(5);
    chk("R11", "entry restored", int'(rd_valid), 1);
    chk("R11", "entry level", int'(rd_level), 10);
    chk("R11", "err replaced", int'(cal_err), 0);
    check_table();
  endtask

  task automatic t_busy_start();
    int cyc;
    set_linear();
    begin_run();
    finish_run(1, 20, cyc);
    chk("R10", "run length with extra start", cyc, base_cyc);
    chk("R10", "no second run", int'(busy), 0);
    check_table();
  endtask

  initial begin
    set_linear();
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_linear();
    t_nonlinear();
    t_missing();
    t_rerun();
    t_busy_start();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule